// File: doc/BRIEF.md
# Synthesizer Control Word Sequencer

This block drives a serial direct-digital-synthesis generator through a write-only SPI link. A host issues one high-level command at a time (power-up initialisation, reset control, tuning-word load, phase load, register select, or output-option change). The block turns each command into one or more 16-bit SPI frames that carry the generator's register address prefixes. It also keeps a shadow copy of the generator's 16-bit control register, so that any change to a control bit rewrites the complete word.

A tuning word is 28 bits wide and is loaded into one of two frequency registers. The load takes three frames: a control word that arms two-part loading, then the low 14 bits, then the high 14 bits. With a 16 MHz generator clock, the tuning word equals f_out * 2^28 / 16e6. For example, 0x1000000 gives 1 MHz.

The host sees a single `cmd_ready` flag. A command is accepted only on a cycle in which `cmd_valid` and `cmd_ready` are both high. The serial clock is the system clock divided by a parameter.

Top module: `dds_ctl_seq`

## Requirements
- R1: Every frame is 16 bits, sent MSB first, with SCLK idling high. MOSI changes only while SCLK is high and is sampled on SCLK falling edges. CS_N falls before the first falling edge and rises only after the rising edge that follows the 16th falling edge.
- R2: One SCLK period is 2*CLK_HALF system clocks. Between consecutive frames, CS_N stays high for at least two SCLK periods.
- R3: Op 2 loads a tuning word and sends three frames in this order: 0x2000, then prefix|data[13:0], then prefix|data[27:14]. The prefix is 0x4000 when sel=0 and 0x8000 when sel=1.
- R4: Op 3 loads a phase register and sends one frame: (sel ? 0xE000 : 0xC000) | data[11:0]. Data bits above bit 11 are ignored.
- R5: Op 1 sets (sel=1) or clears (sel=0) shadow bit 0x0100. Op 4 does the same for bit 0x0800, and op 5 for bit 0x0400. Each of these ops sends the complete updated shadow word as one frame.
- R6: Op 6 changes the output options and sends the updated shadow word. The value of data[2:0] selects the change:
  - 0 clears mask 0x003A (no sign output).
  - 1 sets the field to 0x0028 (MSB output).
  - 2 sets the field to 0x0020 (MSB/2 output).
  - 3 sets the field to 0x0038 (comparator output).
  - 4 sets the field to 0x0002 (triangle).
  - 5 clears only bit 0x0002 (sine).
  - 6 and 7 leave the shadow unchanged.
- R7: Op 0 initialises the generator with 11 frames, in this order: shadow|0x0100 sent twice; 0x2000, 0x4000, 0x4000; 0x2000, 0x8000, 0x8000; 0xC000; 0xE000; and finally shadow with bit 0x0100 cleared. When the op ends, the shadow has bit 0x0100 clear.
- R8: `cmd_ready` goes low in the cycle after a command is accepted. It stays low until the last frame's inter-frame gap has ended. Any `cmd_valid` that arrives while `cmd_ready` is low is ignored.
- R9: Op 7 is a no-op. It sends no frame and leaves the shadow unchanged.
- R10: After reset, the shadow is 0x0000, CS_N and SCLK are high, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (0 init, 1 reset bit, 2 tuning load, 3 phase load, 4 frequency select, 5 phase select, 6 options, 7 no-op) |
| cmd_sel | input | 1 | Register select or bit value |
| cmd_data | input | 28 | Tuning word, phase value or option code |
| cmd_ready | output | 1 | High when a command can be accepted |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the generator |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench decodes the SPI lines on their own edges and compares each received frame sequence with the sequence that the requirement formulas give. This exposes several kinds of error:
- Swapping the two tuning-word halves, or using the wrong prefix, shows up as a wrong second or third frame.
- An option change that clears the whole field when sine is chosen leaves the comparator bits missing from the next frame.
- A shadow that forgets its reset or select bits shows up in the first and last frames of initialisation.

A request that is held while the block is busy must not add a frame. A design that lets chip select rise too soon, or that does not hold the inter-frame gap, trips the frame-length and gap monitors.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;

  localparam int FRAME_W = 16;
  localparam int TUNE_W  = 28;
  localparam int HALF_TW = TUNE_W / 2;
  localparam int PH_W    = 12;
  localparam int STEP_W  = 4;

  typedef enum logic [2:0] {
    OP_INIT   = 3'd0,
    OP_RESET  = 3'd1,
    OP_FREQ   = 3'd2,
    OP_PHASE  = 3'd3,
    OP_FSEL   = 3'd4,
    OP_PSEL   = 3'd5,
    OP_OPTION = 3'd6,
    OP_NOP    = 3'd7
  } op_e;

  localparam logic [15:0] W_ARM     = 16'h2000;
  localparam logic [15:0] PFX_F0    = 16'h4000;
  localparam logic [15:0] PFX_F1    = 16'h8000;
  localparam logic [15:0] PFX_P0    = 16'hC000;
  localparam logic [15:0] PFX_P1    = 16'hE000;
  localparam logic [15:0] B_RESET   = 16'h0100;
  localparam logic [15:0] B_FSEL    = 16'h0800;
  localparam logic [15:0] B_PSEL    = 16'h0400;
  localparam logic [15:0] M_OPT     = 16'h003A;
  localparam logic [15:0] B_TRI     = 16'h0002;

  function automatic logic [15:0] set_bit(logic [15:0] sh, logic [15:0] b, logic v);
    return v ? (sh | b) : (sh & ~b);
  endfunction

  function automatic logic [15:0] apply_cmd(op_e op, logic sel, logic [TUNE_W-1:0] d,
                                            logic [15:0] sh);
    logic [15:0] r;
    r = sh;
    case (op)
      OP_INIT:  r = sh | B_RESET;
      OP_RESET: r = set_bit(sh, B_RESET, sel);
      OP_FSEL:  r = set_bit(sh, B_FSEL, sel);
      OP_PSEL:  r = set_bit(sh, B_PSEL, sel);
      OP_OPTION:
        case (d[2:0])
          3'd0: r = sh & ~M_OPT;
          3'd1: r = (sh & ~M_OPT) | 16'h0028;
          3'd2: r = (sh & ~M_OPT) | 16'h0020;
          3'd3: r = (sh & ~M_OPT) | 16'h0038;
          3'd4: r = (sh & ~M_OPT) | B_TRI;
          3'd5: r = sh & ~B_TRI;
          default: r = sh;
        endcase
      default: r = sh;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] freq_frame(logic [1:0] k, logic hi_reg,
                                             logic [TUNE_W-1:0] w);
    logic [15:0] pfx;
    pfx = hi_reg ? PFX_F1 : PFX_F0;
    case (k)
      2'd0:    return W_ARM;
      2'd1:    return pfx | {2'b00, w[HALF_TW-1:0]};
      default: return pfx | {2'b00, w[TUNE_W-1:HALF_TW]};
    endcase
  endfunction

  function automatic logic [15:0] seq_frame(op_e op, logic sel, logic [TUNE_W-1:0] d,
                                            logic [15:0] sh, logic [STEP_W-1:0] step);
    logic [15:0] r;
    r = sh;
    case (op)
      OP_INIT:
        if (step <= 4'd1)      r = sh;
        else if (step <= 4'd4) r = freq_frame(2'(step - 4'd2), 1'b0, '0);
        else if (step <= 4'd7) r = freq_frame(2'(step - 4'd5), 1'b1, '0);
        else if (step == 4'd8) r = PFX_P0;
        else if (step == 4'd9) r = PFX_P1;
        else                   r = sh & ~B_RESET;
      OP_FREQ:  r = freq_frame(step[1:0], sel, d);
      OP_PHASE: r = (sel ? PFX_P1 : PFX_P0) | {4'b0000, d[PH_W-1:0]};
      default:  r = sh;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dds_spi_tx.sv
module dds_spi_tx #(
  parameter int CLK_HALF   = 2,
  parameter int GAP_HALVES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] frame,
  output logic        done,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n
);
  import dds_seq_pkg::*;

  localparam int CNT_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam int GAP_W = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

  typedef enum logic [2:0] {T_IDLE, T_LEAD, T_LOW, T_HIGH, T_TAIL, T_GAP} tst_e;

  tst_e               state;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bitn;
  logic [GAP_W-1:0]   gapn;
  logic [FRAME_W-1:0] shreg;
  logic               half_end;

  assign half_end = (cnt == CNT_W'(CLK_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= T_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      gapn  <= '0;
      shreg <= '0;
      sclk  <= 1'b1;
      mosi  <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state != T_IDLE) cnt <= half_end ? '0 : cnt + 1'b1;
      case (state)
        T_IDLE:
          if (start) begin
            shreg <= frame;
            mosi  <= frame[FRAME_W-1];
            cs_n  <= 1'b0;
            bitn  <= '0;
            cnt   <= '0;
            state <= T_LEAD;
          end
        T_LEAD:
          if (half_end) begin
            sclk  <= 1'b0;
            state <= T_LOW;
          end
        T_LOW:
          if (half_end) begin
            sclk <= 1'b1;
            if (bitn == BIT_W'(FRAME_W - 1)) begin
              state <= T_TAIL;
            end else begin
              mosi  <= shreg[FRAME_W-2];
              shreg <= shreg << 1;
              bitn  <= bitn + 1'b1;
              state <= T_HIGH;
            end
          end
        T_HIGH:
          if (half_end) begin
            sclk  <= 1'b0;
            state <= T_LOW;
          end
        T_TAIL:
          if (half_end) begin
            cs_n  <= 1'b1;
            gapn  <= '0;
            state <= T_GAP;
          end
        T_GAP:
          if (half_end) begin
            if (gapn == GAP_W'(GAP_HALVES - 1)) begin
              done  <= 1'b1;
              state <= T_IDLE;
            end else begin
              gapn <= gapn + 1'b1;
            end
          end
        default: state <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dds_cmd_seq.sv
module dds_cmd_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic        cmd_sel,
  input  logic [27:0] cmd_data,
  output logic        cmd_ready,
  output logic        tx_start,
  output logic [15:0] tx_frame,
  input  logic        tx_done
);
  import dds_seq_pkg::*;

  typedef enum logic [1:0] {Q_IDLE, Q_SEND, Q_WAIT, Q_FIN} qst_e;

  qst_e              qstate;
  op_e               op_q;
  logic              sel_q;
  logic [TUNE_W-1:0] data_q;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] last;
  logic [15:0]       shadow;
  op_e               op_in;

  assign op_in    = op_e'(cmd_op);
  assign tx_start = (qstate == Q_SEND);
  assign tx_frame = seq_frame(op_q, sel_q, data_q, shadow, step);

  always_ff @(posedge clk) begin
    if (rst) begin
      qstate    <= Q_IDLE;
      op_q      <= OP_NOP;
      sel_q     <= 1'b0;
      data_q    <= '0;
      step      <= '0;
      last      <= '0;
      shadow    <= '0;
      cmd_ready <= 1'b1;
    end else begin
      case (qstate)
        Q_IDLE:
          if (cmd_valid && cmd_ready) begin
            cmd_ready <= 1'b0;
            op_q      <= op_in;
            sel_q     <= cmd_sel;
            data_q    <= cmd_data;
            step      <= '0;
            shadow    <= apply_cmd(op_in, cmd_sel, cmd_data, shadow);
            case (op_in)
              OP_INIT: last <= 4'd10;
              OP_FREQ: last <= 4'd2;
              default: last <= 4'd0;
            endcase
            qstate <= (op_in == OP_NOP) ? Q_FIN : Q_SEND;
          end
        Q_SEND: qstate <= Q_WAIT;
        Q_WAIT:
          if (tx_done) begin
            if (step == last) begin
              if (op_q == OP_INIT) shadow <= shadow & ~B_RESET;
              qstate <= Q_FIN;
            end else begin
              step   <= step + 1'b1;
              qstate <= Q_SEND;
            end
          end
        Q_FIN: begin
          cmd_ready <= 1'b1;
          qstate    <= Q_IDLE;
        end
        default: qstate <= Q_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dds_ctl_seq.sv
module dds_ctl_seq #(
  parameter int CLK_HALF   = 2,
  parameter int GAP_HALVES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic        cmd_sel,
  input  logic [27:0] cmd_data,
  output logic        cmd_ready,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n
);

  logic        tx_start;
  logic        tx_done;
  logic [15:0] tx_frame;

  dds_cmd_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_sel   (cmd_sel),
    .cmd_data  (cmd_data),
    .cmd_ready (cmd_ready),
    .tx_start  (tx_start),
    .tx_frame  (tx_frame),
    .tx_done   (tx_done)
  );

  dds_spi_tx #(
    .CLK_HALF   (CLK_HALF),
    .GAP_HALVES (GAP_HALVES)
  ) u_tx (
    .clk   (clk),
    .rst   (rst),
    .start (tx_start),
    .frame (tx_frame),
    .done  (tx_done),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .cs_n  (spi_cs_n)
  );

endmodule

// File: rtl/dds_seq_chk.sv
module dds_seq_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n
);

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> spi_sclk);

  // R1
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!spi_sclk && $past(!spi_sclk)) |-> $stable(spi_mosi));

  // R1
  cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> spi_sclk);

  // R8
  busy_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> !cmd_ready);

  // R8
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

bind dds_ctl_seq dds_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n)
);

// File: tb/sim_dds_ctl_seq.sv
`timescale 1ns/1ps
module sim_dds_ctl_seq;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd7;
  logic        cmd_sel = 1'b0;
  logic [27:0] cmd_data = '0;
  logic        cmd_ready, spi_sclk, spi_mosi, spi_cs_n;

  int checks = 0;
  int errors = 0;

  logic [15:0] rx [0:15];
  int          rx_n = 0;
  logic [15:0] exp_f [0:15];
  int          exp_n = 0;
  logic [15:0] sh_model = 16'h0000;
  logic [15:0] sreg = '0;
  int          nb = 0;
  bit          len_bad = 0;
  bit          gap_bad = 0;
  bit          idle_bad = 0;
  int          hi_cnt = 0;
  bit          prev_cs = 1'b1;
  bit          seen = 0;

  always #2 clk = ~clk;

  dds_ctl_seq #(.CLK_HALF(HALF), .GAP_HALVES(4)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  always @(negedge spi_sclk) if (!rst && !spi_cs_n) begin
    sreg = {sreg[14:0], spi_mosi};
    nb++;
  end

  always @(posedge spi_cs_n) if (nb != 0) begin
    if (nb != 16) len_bad = 1;
    if (rx_n < 16) rx[rx_n] = sreg;
    rx_n++;
    nb = 0;
  end

  always @(negedge clk) if (!rst) begin
    if (spi_cs_n && !spi_sclk) idle_bad = 1;
    if (spi_cs_n) hi_cnt++;
    else begin
      if (prev_cs && seen && hi_cnt < 4 * HALF) gap_bad = 1;
      hi_cnt = 0;
      seen = 1;
    end
    prev_cs = spi_cs_n;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic start_cmd(logic [2:0] op, logic sel, logic [27:0] d);
    while (!cmd_ready) @(negedge clk);
    rx_n = 0;
    cmd_op = op; cmd_sel = sel; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R8 ready low after accept", cmd_ready, 0);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!cmd_ready && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic compare(string req);
    chk(rx_n == exp_n, req, rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      chk(rx[i] == exp_f[i], req, rx[i], exp_f[i]);
    chk(!len_bad, "R1 frame length", len_bad, 0);
  endtask

  task automatic run1(logic [2:0] op, logic sel, logic [27:0] d, string req);
    start_cmd(op, sel, d);
    wait_idle();
    compare(req);
  endtask

  task automatic t_reset();
    chk(spi_cs_n == 1'b1, "R10 cs idle", spi_cs_n, 1);
    chk(spi_sclk == 1'b1, "R10 sclk idle", spi_sclk, 1);
    chk(cmd_ready == 1'b1, "R10 ready", cmd_ready, 1);
    exp_n = 1; exp_f[0] = 16'h0000;
    run1(3'd6, 1'b0, 28'd7, "R10 shadow zero");
  endtask

  task automatic t_freq(logic sel, logic [27:0] w);
    logic [15:0] p = sel ? 16'h8000 : 16'h4000;
    exp_n = 3;
    exp_f[0] = 16'h2000;
    exp_f[1] = p | {2'b00, w[13:0]};
    exp_f[2] = p | {2'b00, w[27:14]};
    run1(3'd2, sel, w, "R3 tuning load");
    chk(!gap_bad, "R2 inter-frame gap", gap_bad, 0);
  endtask

  task automatic t_phase(logic sel, logic [27:0] d);
    exp_n = 1;
    exp_f[0] = (sel ? 16'hE000 : 16'hC000) | {4'h0, d[11:0]};
    run1(3'd3, sel, d, "R4 phase load");
  endtask

  task automatic t_ctrl(logic [2:0] op, logic sel, logic [15:0] newsh, string req);
    sh_model = newsh;
    exp_n = 1; exp_f[0] = newsh;
    run1(op, sel, 28'd0, req);
  endtask

  task automatic t_opt(logic [2:0] code, logic [15:0] newsh);
    sh_model = newsh;
    exp_n = 1; exp_f[0] = newsh;
    run1(3'd6, 1'b0, {25'd0, code}, "R6 option");
  endtask

  task automatic t_init();
    exp_n = 11;
    exp_f[0] = sh_model | 16'h0100; exp_f[1] = sh_model | 16'h0100;
    exp_f[2] = 16'h2000; exp_f[3] = 16'h4000; exp_f[4] = 16'h4000;
    exp_f[5] = 16'h2000; exp_f[6] = 16'h8000; exp_f[7] = 16'h8000;
    exp_f[8] = 16'hC000; exp_f[9] = 16'hE000;
    exp_f[10] = sh_model & ~16'h0100;
    sh_model = sh_model & ~16'h0100;
    run1(3'd0, 1'b0, 28'd0, "R7 init order");
    exp_n = 1; exp_f[0] = sh_model;
    run1(3'd6, 1'b0, 28'd6, "R7 shadow after init");
  endtask

  task automatic t_nop();
    int n;
    start_cmd(3'd7, 1'b0, 28'h0);
    wait_idle();
    for (n = 0; n < 60; n++) @(negedge clk);
    chk(rx_n == 0, "R9 no-op frames", rx_n, 0);
    exp_n = 1; exp_f[0] = sh_model;
    run1(3'd6, 1'b0, 28'd7, "R9 shadow unchanged");
  endtask

  task automatic t_busy();
    start_cmd(3'd2, 1'b1, 28'h0ABCDEF);
    cmd_op = 3'd3; cmd_sel = 1'b1; cmd_data = 28'h555; cmd_valid = 1'b1;
    repeat (40) @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    exp_n = 3;
    exp_f[0] = 16'h2000;
    exp_f[1] = 16'h8000 | 16'(28'h0ABCDEF & 28'h3FFF);
    exp_f[2] = 16'h8000 | 16'(28'h0ABCDEF >> 14);
    compare("R8 busy request ignored");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_init();
    t_freq(1'b1, 28'd16777216);
    t_freq(1'b0, 28'd33554432);
    t_freq(1'b0, 28'h0ABCDEF);
    t_phase(1'b1, 28'h123);
    t_phase(1'b0, 28'hFFFFFFF);
    t_ctrl(3'd4, 1'b1, 16'h0800, "R5 freq select");
    t_ctrl(3'd5, 1'b1, 16'h0C00, "R5 phase select");
    t_opt(3'd1, 16'h0C28);
    t_opt(3'd4, 16'h0C02);
    t_opt(3'd3, 16'h0C38);
    t_opt(3'd5, 16'h0C38);
    t_opt(3'd2, 16'h0C20);
    t_opt(3'd0, 16'h0C00);
    t_opt(3'd3, 16'h0C38);
    t_ctrl(3'd1, 1'b1, 16'h0D38, "R5 reset set");
    t_ctrl(3'd4, 1'b0, 16'h0538, "R5 freq select clear");
    t_init();
    t_nop();
    t_busy();
    chk(!gap_bad, "R2 inter-frame gap", gap_bad, 0);
    chk(!idle_bad, "R1 sclk idles high", idle_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule